// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is the storage and output stage that sits behind one sum-of-products term in a programmable logic array. A single-bit product-term sum enters the cell, passes through a storage stage chosen by static configuration (straight-through, edge-triggered D, toggle, or level-sensitive latch), and leaves through an optional inversion.

The result always returns to the interconnect on a feedback output. A pin path, with its own output enable, carries the same value when the cell is not buried. The clock comes from a parameterized set of global clocks. A block-wide active-low asynchronous reset and preset act on the storage stage.

A buried cell may instead be set up to capture its pad input. It can do this with a rising-edge register or with a latch that is transparent while the selected clock is low. In that setting the product-term input has no path to the output.

Top module: `pld_macrocell`

## Requirements
- R1: `fb_o` carries the cell result in every configuration, and `pin_o` always equals `fb_o`.
- R2: With `cfg_mode_i` = 0 (straight-through) and no input capture, `fb_o` equals `sop_i` XOR `cfg_invert_i` without waiting for a clock edge.
- R3: `pin_oe_o` is 1 only when `oe_i` = 1 and `cfg_buried_i` = 0; otherwise it is 0.
- R4: With `cfg_mode_i` = 1 (D register), the stored bit takes `sop_i` on each rising edge of the selected clock.
- R5: With `cfg_mode_i` = 2 (toggle register), the stored bit inverts on a rising edge of the selected clock when `sop_i` = 1, and holds when `sop_i` = 0.
- R6: With `cfg_mode_i` = 3 (latch), the stored bit follows `sop_i` while the selected clock is low and holds while it is high.
- R7: The selected clock is `clks_i[cfg_clk_sel_i]`; edges on any other clock leave the stored bit unchanged.
- R8: With `cfg_invert_i` = 1, the stored or bypassed value is inverted on both `fb_o` and `pin_o`.
- R9: While `rst_ni` = 0, the stored bit is 0, even when `preset_ni` = 0 at the same time.
- R10: While `preset_ni` = 0 and `rst_ni` = 1, the stored bit is 1.
- R11: With `cfg_buried_i` = 1, `cfg_in_en_i` = 1 and `cfg_in_latch_i` = 0, the stored bit takes `pin_i` on each rising edge of the selected clock. `sop_i` and `cfg_mode_i` are ignored in this setting.
- R12: With `cfg_buried_i` = 1, `cfg_in_en_i` = 1 and `cfg_in_latch_i` = 1, the stored bit follows `pin_i` while the selected clock is low and holds while it is high. `sop_i` and `cfg_mode_i` are ignored in this setting.
- R13: When `cfg_buried_i` = 0, `cfg_in_en_i` has no effect and the cell works from `sop_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clks_i | input | NUM_CLKS | Global clock set |
| rst_ni | input | 1 | Block asynchronous reset, active low, overrides preset |
| preset_ni | input | 1 | Block asynchronous preset, active low |
| sop_i | input | 1 | Sum-of-products term from the logic array |
| pin_i | input | 1 | Pad input, used only by a buried capture cell |
| oe_i | input | 1 | Output enable request for the pin path |
| cfg_mode_i | input | 2 | Storage mode: 0 bypass, 1 D, 2 toggle, 3 latch |
| cfg_clk_sel_i | input | SEL_W | Index of the clock used by this cell |
| cfg_invert_i | input | 1 | Invert the result after storage |
| cfg_buried_i | input | 1 | Cell drives no pin |
| cfg_in_en_i | input | 1 | Buried cell captures `pin_i` instead of `sop_i` |
| cfg_in_latch_i | input | 1 | Capture with a low-transparent latch rather than a register |
| fb_o | output | 1 | Feedback to the interconnect |
| pin_o | output | 1 | Pin data |
| pin_oe_o | output | 1 | Pin drive enable; 0 means high impedance |

## Verification
The bench builds the cell with `NUM_CLKS` = 4, so the clock select is two bits wide. This puts every selector code within reach, along with the case of a pulse on a clock that is not selected. Pulses on the unselected clocks are mixed in while the stored value is known. This lets a wrong mux index or a cell that reacts to every clock show up as a changed output. With four clocks, the logic latch and the input latch can also be run on different clocks from the registered modes.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  typedef enum logic [1:0] {
    ST_COMB  = 2'd0,
    ST_DFF   = 2'd1,
    ST_TFF   = 2'd2,
    ST_LATCH = 2'd3
  } store_mode_e;
endpackage

// File: rtl/mcell_clk_sel.sv
module mcell_clk_sel #(
  parameter int NUM_CLKS = 4,
  localparam int SEL_W = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1
) (
  input  logic [NUM_CLKS-1:0] clks_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                clk_o
);
  generate
    if (NUM_CLKS == 1) begin : g_single
      assign clk_o = clks_i[0];
    end else begin : g_mux
      assign clk_o = clks_i[sel_i];
    end
  endgenerate
endmodule

// File: rtl/mcell_src_sel.sv
module mcell_src_sel
  import mcell_pkg::*;
(
  input  store_mode_e mode_i,
  input  logic        buried_i,
  input  logic        in_en_i,
  input  logic        in_latch_i,
  input  logic        sop_i,
  input  logic        pin_i,
  output store_mode_e mode_o,
  output logic        d_o
);
  logic capture;

  // input capture exists only on a buried cell
  assign capture = buried_i & in_en_i;

  always_comb begin
    if (capture) begin
      mode_o = in_latch_i ? ST_LATCH : ST_DFF;
      d_o    = pin_i;
    end else begin
      mode_o = mode_i;
      d_o    = sop_i;
    end
  end
endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        preset_ni,
  input  store_mode_e mode_i,
  input  logic        d_i,
  output logic        q_o
);
  logic ff_q;
  logic lat_q;

  // reset wins over preset
  always_ff @(posedge clk_i or negedge rst_ni or negedge preset_ni) begin
    if (!rst_ni)                ff_q <= 1'b0;
    else if (!preset_ni)        ff_q <= 1'b1;
    else if (mode_i == ST_TFF)  ff_q <= ff_q ^ d_i;
    else                        ff_q <= d_i;
  end

  // transparent while the selected clock is low
  always_latch begin
    if (!rst_ni)         lat_q <= 1'b0;
    else if (!preset_ni) lat_q <= 1'b1;
    else if (!clk_i)     lat_q <= d_i;
  end

  always_comb begin
    unique case (mode_i)
      ST_COMB:  q_o = d_i;
      ST_LATCH: q_o = lat_q;
      default:  q_o = ff_q;
    endcase
  end
endmodule

// File: rtl/mcell_out.sv
module mcell_out (
  input  logic result_i,
  input  logic invert_i,
  input  logic buried_i,
  input  logic oe_i,
  output logic fb_o,
  output logic pin_o,
  output logic pin_oe_o
);
  logic polar;

  assign polar    = result_i ^ invert_i;
  assign fb_o     = polar;
  assign pin_o    = polar;
  assign pin_oe_o = oe_i & ~buried_i;
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import mcell_pkg::*;
#(
  parameter int NUM_CLKS = 4,
  localparam int SEL_W = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1
) (
  input  logic [NUM_CLKS-1:0] clks_i,
  input  logic                rst_ni,
  input  logic                preset_ni,
  input  logic                sop_i,
  input  logic                pin_i,
  input  logic                oe_i,
  input  logic [1:0]          cfg_mode_i,
  input  logic [SEL_W-1:0]    cfg_clk_sel_i,
  input  logic                cfg_invert_i,
  input  logic                cfg_buried_i,
  input  logic                cfg_in_en_i,
  input  logic                cfg_in_latch_i,
  output logic                fb_o,
  output logic                pin_o,
  output logic                pin_oe_o
);
  logic        sel_clk;
  store_mode_e eff_mode;
  logic        data;
  logic        result;

  mcell_clk_sel #(.NUM_CLKS(NUM_CLKS)) u_clk_sel (
    .clks_i (clks_i),
    .sel_i  (cfg_clk_sel_i),
    .clk_o  (sel_clk)
  );

  mcell_src_sel u_src_sel (
    .mode_i     (store_mode_e'(cfg_mode_i)),
    .buried_i   (cfg_buried_i),
    .in_en_i    (cfg_in_en_i),
    .in_latch_i (cfg_in_latch_i),
    .sop_i      (sop_i),
    .pin_i      (pin_i),
    .mode_o     (eff_mode),
    .d_o        (data)
  );

  mcell_store u_store (
    .clk_i     (sel_clk),
    .rst_ni    (rst_ni),
    .preset_ni (preset_ni),
    .mode_i    (eff_mode),
    .d_i       (data),
    .q_o       (result)
  );

  mcell_out u_out (
    .result_i (result),
    .invert_i (cfg_invert_i),
    .buried_i (cfg_buried_i),
    .oe_i     (oe_i),
    .fb_o     (fb_o),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk #(
  parameter int NUM_CLKS = 4,
  localparam int SEL_W = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             preset_ni,
  input logic             sop_i,
  input logic             pin_i,
  input logic             oe_i,
  input logic [1:0]       cfg_mode_i,
  input logic [SEL_W-1:0] cfg_clk_sel_i,
  input logic             cfg_invert_i,
  input logic             cfg_buried_i,
  input logic             cfg_in_en_i,
  input logic             cfg_in_latch_i,
  input logic             fb_o,
  input logic             pin_oe_o
);
  logic armed;
  logic capture;
  logic [SEL_W+5:0] cfg_vec;

  assign capture = cfg_buried_i & cfg_in_en_i;
  assign cfg_vec = {cfg_mode_i, cfg_clk_sel_i, cfg_invert_i, cfg_buried_i,
                    cfg_in_en_i, cfg_in_latch_i};

  // previous selected-clock edge came after the last reset or preset
  always_ff @(posedge clk_i or negedge rst_ni or negedge preset_ni) begin
    if (!rst_ni || !preset_ni) armed <= 1'b0;
    else                       armed <= 1'b1;
  end

  p_comb_path_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture && cfg_mode_i == 2'd0) |-> (fb_o == (sop_i ^ cfg_invert_i)));

  p_pin_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_buried_i || !oe_i) |-> !pin_oe_o);

  p_dreg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !preset_ni)
    (armed && $stable(cfg_vec) && !capture && cfg_mode_i == 2'd1)
      |-> (fb_o == ($past(sop_i) ^ cfg_invert_i)));

  p_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !preset_ni)
    (armed && $stable(cfg_vec) && !capture && cfg_mode_i == 2'd2)
      |-> (fb_o == ($past(fb_o) ^ $past(sop_i))));

  p_preset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preset_ni && (capture || cfg_mode_i != 2'd0)) |-> (fb_o == !cfg_invert_i));

  p_inreg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !preset_ni)
    (armed && $stable(cfg_vec) && capture && !cfg_in_latch_i)
      |-> (fb_o == ($past(pin_i) ^ cfg_invert_i)));
endmodule

bind pld_macrocell pld_macrocell_chk #(.NUM_CLKS(NUM_CLKS)) u_chk (
  .clk_i          (sel_clk),
  .rst_ni         (rst_ni),
  .preset_ni      (preset_ni),
  .sop_i          (sop_i),
  .pin_i          (pin_i),
  .oe_i           (oe_i),
  .cfg_mode_i     (cfg_mode_i),
  .cfg_clk_sel_i  (cfg_clk_sel_i),
  .cfg_invert_i   (cfg_invert_i),
  .cfg_buried_i   (cfg_buried_i),
  .cfg_in_en_i    (cfg_in_en_i),
  .cfg_in_latch_i (cfg_in_latch_i),
  .fb_o           (fb_o),
  .pin_oe_o       (pin_oe_o)
);

// File: tb/pld_macrocell_bench.sv
module pld_macrocell_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CLKS   = 4;
  localparam int SEL_W      = 2;
  localparam int NVEC       = 16;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] sel;
    logic       inv;
    logic       bur;
    logic       in_en;
    logic       in_lat;
    logic       sop;
    logic       pin;
    logic       pulse;
    logic [1:0] pclk;
    logic       exp_fb;
    logic       exp_oe;
  } vec_t;

  // mode sel inv bur in_en in_lat sop pin pulse pclk exp_fb exp_oe
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1},
    '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},
    '{2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b1},
    '{2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1},
    '{2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1},
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1},
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1},
    '{2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1},
    '{2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1},
    '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1},
    '{2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
    '{2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},
    '{2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0},
    '{2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1}
  };

  localparam string TAGS [NVEC] = '{
    "R2", "R8", "R4", "R7", "R7", "R5", "R5", "R5",
    "R8", "R6", "R6", "R4", "R11", "R11", "R12", "R13"
  };

  logic [NUM_CLKS-1:0] clks = '1;
  logic rst_ni = 1'b0;
  logic preset_ni = 1'b1;
  logic sop = 1'b0, pin = 1'b0, oe = 1'b1;
  logic [1:0] mode = 2'd1;
  logic [SEL_W-1:0] sel = '0;
  logic inv = 1'b0, bur = 1'b0, in_en = 1'b0, in_lat = 1'b0;
  logic fb, pin_o, pin_oe;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  pld_macrocell #(.NUM_CLKS(NUM_CLKS)) u_pld_macrocell (
    .clks_i         (clks),
    .rst_ni         (rst_ni),
    .preset_ni      (preset_ni),
    .sop_i          (sop),
    .pin_i          (pin),
    .oe_i           (oe),
    .cfg_mode_i     (mode),
    .cfg_clk_sel_i  (sel),
    .cfg_invert_i   (inv),
    .cfg_buried_i   (bur),
    .cfg_in_en_i    (in_en),
    .cfg_in_latch_i (in_lat),
    .fb_o           (fb),
    .pin_o          (pin_o),
    .pin_oe_o       (pin_oe)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pulse(input int k);
    clks[k] = 1'b0;
    #(CLK_PERIOD/2);
    clks[k] = 1'b1;
    #(CLK_PERIOD/2);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset state, D mode
    #(CLK_PERIOD);
    chk("R9 reset", fb, 1'b0);
    chk("R3 oe after reset", pin_oe, 1'b1);
    rst_ni = 1'b1;
    #(CLK_PERIOD);

    for (int i = 0; i < NVEC; i++) begin
      mode = VECS[i].mode; sel = VECS[i].sel; inv = VECS[i].inv;
      bur = VECS[i].bur; in_en = VECS[i].in_en; in_lat = VECS[i].in_lat;
      sop = VECS[i].sop; pin = VECS[i].pin;
      #1;
      if (VECS[i].pulse) pulse(int'(VECS[i].pclk));
      else #(CLK_PERIOD);
      #1;
      chk(TAGS[i], fb, VECS[i].exp_fb);
      chk("R1 pin equals feedback", pin_o, fb);
      chk("R3 pin enable", pin_oe, VECS[i].exp_oe);
    end

    // R12: input latch transparent while clock 1 is low
    bur = 1'b1; in_en = 1'b1; in_lat = 1'b1; sel = 2'd1; inv = 1'b0;
    mode = 2'd2; sop = 1'b1; pin = 1'b0;
    #1; clks[1] = 1'b0; #2;
    chk("R12 transparent 0", fb, 1'b0);
    pin = 1'b1; #2;
    chk("R12 transparent 1", fb, 1'b1);
    clks[1] = 1'b1; #1; pin = 1'b0; sop = 1'b0; #2;
    chk("R12 hold while high", fb, 1'b1);

    // R6: logic latch on clock 2
    bur = 1'b0; in_en = 1'b0; in_lat = 1'b0; mode = 2'd3; sel = 2'd2;
    #1; clks[2] = 1'b0; sop = 1'b0; #2;
    chk("R6 follow 0", fb, 1'b0);
    sop = 1'b1; #2;
    chk("R6 follow 1", fb, 1'b1);
    clks[2] = 1'b1; #1; sop = 1'b0; #2;
    chk("R6 hold while high", fb, 1'b1);

    // R10 preset, R8 with inversion, R9 priority
    mode = 2'd1; sel = 2'd0; #1;
    pulse(0);
    chk("R4 load zero", fb, 1'b0);
    preset_ni = 1'b0; #2;
    chk("R10 preset", fb, 1'b1);
    inv = 1'b1; #2;
    chk("R8 preset inverted", fb, 1'b0);
    chk("R1 pin inverted", pin_o, 1'b0);
    inv = 1'b0; rst_ni = 1'b0; #2;
    chk("R9 reset over preset", fb, 1'b0);
    preset_ni = 1'b1; #2;
    rst_ni = 1'b1; #2;
    chk("R9 after release", fb, 1'b0);

    // R3: output enable low on a pin cell
    oe = 1'b0; #2;
    chk("R3 oe low", pin_oe, 1'b0);
    oe = 1'b1; #2;
    chk("R3 oe high", pin_oe, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule